// File: doc/BRIEF.md
# Set-Associative Cache Lookup and Fill Engine

The engine accepts one word address per clock while `req_valid` is high. It splits the address into a tag, a set index and a word offset. It then compares the tag against every way of the selected set at once and reports a hit or a miss. On a miss it loads the entire aligned block that contains the requested word from a modelled backing store, in which every word holds its own address as its value.

The engine picks a victim way per reference. An invalid way is always used first. In a full set, the `policy_mru` input selects the rule, and it may change from one reference to the next. With `policy_mru` low, the way touched longest ago is evicted. With `policy_mru` high, the way touched most recently is evicted.

Parameters shape the engine into a direct-mapped, set-associative or fully associative organisation. Zero index bits give one set, and zero offset bits give one-word blocks.

A small response state machine records the outcome of each reference and drives the registered outputs. It has four states:
- RSP_IDLE: no reference in the previous cycle.
- RSP_HIT: tag match.
- RSP_FILL: miss placed into a free way.
- RSP_EVICT: miss that displaced a valid block.

Every cycle the state machine moves to the state that matches the current reference, or to RSP_IDLE when the strobe is low. Any state can reach any other state.

Top module: `assoc_cache_engine`

## Requirements
- R1: After reset every way is invalid, so the first reference to any address reports a miss, and `resp_valid` is low until a reference is made.
- R2: The address is divided, from most to least significant bit, into TAG_W tag bits, IDX_W index bits and OFF_W offset bits. A reference hits exactly when a valid way of the set named by the index field holds the same tag.
- R3: `resp_valid` and all result outputs refer to the reference strobed on the previous clock edge. `resp_valid` is low in the cycle after a clock with `req_valid` low.
- R4: A miss in a set with a free way fills the lowest-numbered invalid way, reports that way on `resp_way` and keeps `resp_evict` low.
- R5: With `policy_mru` = 0, a miss in a full set replaces the way whose last reference is oldest.
- R6: With `policy_mru` = 1, a miss in a full set replaces the way referenced most recently. The policy is taken per reference, so it can be switched mid-stream.
- R7: A hit reports the matching way, keeps `resp_evict` low, leaves the stored tags unchanged and makes that way the most recent one in its set.
- R8: A miss loads every word of the aligned block. A later reference to any other word of that block hits; for example, a miss on 89 makes 88 hit.
- R9: `resp_word` equals the referenced word address, on hits and on misses.
- R10: In a direct-mapped build (4-bit address: 2 tag bits, 2 index bits, 0 offset bits, 1 way), the sequence 0, 8, 0, 6, 8 produces no hit.
- R11: A fully associative build (0 index bits, one set, 4 ways) behaves as one set under both policies.
- R12: On an eviction, `resp_evict` is high and `resp_evict_tag` carries the tag of the displaced block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | A reference is presented this cycle |
| req_addr | input | ADDR_W | Word address of the reference |
| policy_mru | input | 1 | 0 evicts least recently used, 1 evicts most recently used |
| resp_valid | output | 1 | Result of last cycle's reference is present |
| resp_hit | output | 1 | That reference hit |
| resp_way | output | WAY_W | Way that hit or was filled |
| resp_evict | output | 1 | A valid block was displaced |
| resp_evict_tag | output | TAG_W | Tag of the displaced block |
| resp_word | output | ADDR_W | Data word returned for the reference |

## Verification
The bench builds three instances side by side.
- The default 8-bit build (5/2/1 split, 3 ways) is large enough to show fills, both eviction rules, block-wide loads and a policy switch inside one set.
- A 4-bit direct-mapped build with zero offset bits exercises the one-way, one-word corner.
- An 8-bit build with zero index bits and 4 ways exercises the single-set corner.

Each result is compared with a bench model that tracks last-use timestamps rather than ages.

// File: rtl/cache_pkg.sv
package cache_pkg;
    typedef enum logic [1:0] {
        RSP_IDLE  = 2'd0,
        RSP_HIT   = 2'd1,
        RSP_FILL  = 2'd2,
        RSP_EVICT = 2'd3
    } rsp_state_t;
endpackage

// File: rtl/cache_addr_split.sv
module cache_addr_split #(
    parameter int ADDR_W = 8,
    parameter int TAG_W  = 5,
    parameter int IDX_W  = 2,
    parameter int OFF_W  = 1,
    localparam int IDX_E = (IDX_W > 0) ? IDX_W : 1,
    localparam int OFF_E = (OFF_W > 0) ? OFF_W : 1
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [TAG_W-1:0]  tag,
    output logic [IDX_E-1:0]  idx,
    output logic [OFF_E-1:0]  off
);
    assign tag = addr[ADDR_W-1 -: TAG_W];

    generate
        if (IDX_W > 0) begin : g_idx
            assign idx = addr[OFF_W +: IDX_W];
        end else begin : g_noidx
            assign idx = '0;
        end
        if (OFF_W > 0) begin : g_off
            assign off = addr[OFF_W-1:0];
        end else begin : g_nooff
            assign off = '0;
        end
    endgenerate
endmodule

// File: rtl/cache_way_match.sv
module cache_way_match #(
    parameter int WAYS  = 3,
    parameter int TAG_W = 5,
    parameter int WAY_W = 2
) (
    input  logic [WAYS-1:0]            valid_row,
    input  logic [WAYS-1:0][TAG_W-1:0] tag_row,
    input  logic [TAG_W-1:0]           tag,
    output logic                       hit,
    output logic [WAY_W-1:0]           hit_way
);
    logic [WAYS-1:0] match;

    generate
        for (genvar w = 0; w < WAYS; w++) begin : g_cmp
            assign match[w] = valid_row[w] && (tag_row[w] == tag);
        end
    endgenerate

    always_comb begin
        hit_way = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (match[w]) hit_way = WAY_W'(w);
        end
    end

    assign hit = |match;
endmodule

// File: rtl/cache_victim_pick.sv
module cache_victim_pick #(
    parameter int WAYS  = 3,
    parameter int WAY_W = 2
) (
    input  logic [WAYS-1:0]            valid_row,
    input  logic [WAYS-1:0][WAY_W-1:0] age_row,
    input  logic                       mru,
    output logic [WAY_W-1:0]           victim,
    output logic                       full
);
    logic [WAY_W-1:0] free_way;
    logic [WAY_W-1:0] aged_way;

    assign full = &valid_row;

    always_comb begin
        free_way = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (!valid_row[w]) free_way = WAY_W'(w);
        end
    end

    always_comb begin
        aged_way = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (mru  && age_row[w] == '0)              aged_way = WAY_W'(w);
            if (!mru && age_row[w] == WAY_W'(WAYS - 1)) aged_way = WAY_W'(w);
        end
    end

    assign victim = full ? aged_way : free_way;
endmodule

// File: rtl/assoc_cache_engine.sv
module assoc_cache_engine
    import cache_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int TAG_W  = 5,
    parameter int IDX_W  = 2,
    parameter int OFF_W  = 1,
    parameter int WAYS   = 3,
    localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              policy_mru,
    output logic              resp_valid,
    output logic              resp_hit,
    output logic [WAY_W-1:0]  resp_way,
    output logic              resp_evict,
    output logic [TAG_W-1:0]  resp_evict_tag,
    output logic [ADDR_W-1:0] resp_word
);
    localparam int SETS  = 1 << IDX_W;
    localparam int WORDS = 1 << OFF_W;
    localparam int IDX_E = (IDX_W > 0) ? IDX_W : 1;
    localparam int OFF_E = (OFF_W > 0) ? OFF_W : 1;

    logic [WAYS-1:0]                         valid_q [SETS];
    logic [WAYS-1:0][TAG_W-1:0]              tag_q   [SETS];
    logic [WAYS-1:0][WAY_W-1:0]              age_q   [SETS];
    logic [WAYS-1:0][WORDS-1:0][ADDR_W-1:0]  data_q  [SETS];

    logic [TAG_W-1:0] cur_tag;
    logic [IDX_E-1:0] cur_idx;
    logic [OFF_E-1:0] cur_off;
    logic             hit;
    logic [WAY_W-1:0] hit_way;
    logic [WAY_W-1:0] victim;
    logic             set_full;
    logic [WAY_W-1:0] ref_way;
    logic [WAY_W-1:0] ref_age;
    logic [ADDR_W-1:0] block_base;

    rsp_state_t        state_q, state_d;
    logic [WAY_W-1:0]  way_q;
    logic [TAG_W-1:0]  ev_tag_q;
    logic [ADDR_W-1:0] word_q;

    cache_addr_split #(
        .ADDR_W(ADDR_W), .TAG_W(TAG_W), .IDX_W(IDX_W), .OFF_W(OFF_W)
    ) u_split (
        .addr(req_addr), .tag(cur_tag), .idx(cur_idx), .off(cur_off)
    );

    cache_way_match #(
        .WAYS(WAYS), .TAG_W(TAG_W), .WAY_W(WAY_W)
    ) u_match (
        .valid_row(valid_q[cur_idx]), .tag_row(tag_q[cur_idx]),
        .tag(cur_tag), .hit(hit), .hit_way(hit_way)
    );

    cache_victim_pick #(
        .WAYS(WAYS), .WAY_W(WAY_W)
    ) u_victim (
        .valid_row(valid_q[cur_idx]), .age_row(age_q[cur_idx]),
        .mru(policy_mru), .victim(victim), .full(set_full)
    );

    assign ref_way    = hit ? hit_way : victim;
    assign ref_age    = age_q[cur_idx][ref_way];
    assign block_base = (req_addr >> OFF_W) << OFF_W;

    // next response state: outcome of the reference on this edge
    always_comb begin
        if (!req_valid)    state_d = RSP_IDLE;
        else if (hit)      state_d = RSP_HIT;
        else if (set_full) state_d = RSP_EVICT;
        else               state_d = RSP_FILL;
    end

    // state register with registered result fields
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= RSP_IDLE;
            way_q    <= '0;
            ev_tag_q <= '0;
            word_q   <= '0;
        end else begin
            state_q <= state_d;
            if (req_valid) begin
                way_q    <= ref_way;
                ev_tag_q <= tag_q[cur_idx][victim];
                word_q   <= hit ? data_q[cur_idx][hit_way][cur_off] : req_addr;
            end
        end
    end

    // storage: valid, tag, recency ages
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                valid_q[s] <= '0;
                tag_q[s]   <= '0;
                for (int w = 0; w < WAYS; w++) age_q[s][w] <= WAY_W'(w);
            end
        end else if (req_valid) begin
            if (!hit) begin
                valid_q[cur_idx][ref_way] <= 1'b1;
                tag_q[cur_idx][ref_way]   <= cur_tag;
            end
            for (int w = 0; w < WAYS; w++) begin
                if (WAY_W'(w) == ref_way)          age_q[cur_idx][w] <= '0;
                else if (age_q[cur_idx][w] < ref_age) age_q[cur_idx][w] <= age_q[cur_idx][w] + 1'b1;
            end
        end
    end

    // block data, filled whole on a miss
    always_ff @(posedge clk) begin
        if (req_valid && !hit) begin
            for (int k = 0; k < WORDS; k++) begin
                data_q[cur_idx][ref_way][k] <= block_base | ADDR_W'(k);
            end
        end
    end

    // output process driven from the state
    always_comb begin
        resp_valid     = 1'b0;
        resp_hit       = 1'b0;
        resp_evict     = 1'b0;
        resp_way       = way_q;
        resp_evict_tag = '0;
        resp_word      = word_q;
        unique case (state_q)
            RSP_IDLE: begin
                resp_way  = '0;
                resp_word = '0;
            end
            RSP_HIT: begin
                resp_valid = 1'b1;
                resp_hit   = 1'b1;
            end
            RSP_FILL: begin
                resp_valid = 1'b1;
            end
            RSP_EVICT: begin
                resp_valid     = 1'b1;
                resp_evict     = 1'b1;
                resp_evict_tag = ev_tag_q;
            end
        endcase
    end
endmodule

// File: rtl/assoc_cache_chk.sv
module assoc_cache_chk #(
    parameter int ADDR_W = 8,
    parameter int TAG_W  = 5,
    parameter int WAYS   = 3,
    parameter int WAY_W  = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic [ADDR_W-1:0] req_addr,
    input logic              resp_valid,
    input logic              resp_hit,
    input logic [WAY_W-1:0]  resp_way,
    input logic              resp_evict,
    input logic [TAG_W-1:0]  resp_evict_tag,
    input logic [ADDR_W-1:0] resp_word
);
    assert_resp_follows_R3: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> resp_valid);

    assert_resp_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !resp_valid);

    assert_word_is_addr_R9: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> resp_word == $past(req_addr));

    assert_hit_no_evict_R7: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid && resp_hit |-> !resp_evict);

    assert_way_in_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |-> resp_way < WAY_W'(WAYS - 1) + 1'b1 || WAYS == (1 << WAY_W));

    assert_evict_other_tag_R12: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> !resp_evict || resp_evict_tag != $past(req_addr[ADDR_W-1 -: TAG_W]));
endmodule

bind assoc_cache_engine assoc_cache_chk #(
    .ADDR_W(ADDR_W), .TAG_W(TAG_W), .WAYS(WAYS), .WAY_W(WAY_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .resp_valid(resp_valid), .resp_hit(resp_hit), .resp_way(resp_way),
    .resp_evict(resp_evict), .resp_evict_tag(resp_evict_tag), .resp_word(resp_word)
);

// File: tb/sim_assoc_cache_engine.sv
`timescale 1ns/1ps
module sim_assoc_cache_engine;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    int vectors = 0;
    int miscompares = 0;

    // per-instance stimulus and results
    logic       v0 = 0, v1 = 0, v2 = 0;
    logic [7:0] a0 = 0, a2 = 0;
    logic [3:0] a1 = 0;
    logic       p0 = 0, p1 = 0, p2 = 0;
    logic       rv0, rh0, re0, rv1, rh1, re1, rv2, rh2, re2;
    logic [1:0] rw0, rw2;
    logic [0:0] rw1;
    logic [4:0] rt0;
    logic [1:0] rt1;
    logic [6:0] rt2;
    logic [7:0] rd0, rd2;
    logic [3:0] rd1;

    assoc_cache_engine #(.ADDR_W(8), .TAG_W(5), .IDX_W(2), .OFF_W(1), .WAYS(3)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(v0), .req_addr(a0), .policy_mru(p0),
        .resp_valid(rv0), .resp_hit(rh0), .resp_way(rw0), .resp_evict(re0),
        .resp_evict_tag(rt0), .resp_word(rd0));

    assoc_cache_engine #(.ADDR_W(4), .TAG_W(2), .IDX_W(2), .OFF_W(0), .WAYS(1)) u1 (
        .clk(clk), .rst_n(rst_n), .req_valid(v1), .req_addr(a1), .policy_mru(p1),
        .resp_valid(rv1), .resp_hit(rh1), .resp_way(rw1), .resp_evict(re1),
        .resp_evict_tag(rt1), .resp_word(rd1));

    assoc_cache_engine #(.ADDR_W(8), .TAG_W(7), .IDX_W(0), .OFF_W(1), .WAYS(4)) u2 (
        .clk(clk), .rst_n(rst_n), .req_valid(v2), .req_addr(a2), .policy_mru(p2),
        .resp_valid(rv2), .resp_hit(rh2), .resp_way(rw2), .resp_evict(re2),
        .resp_evict_tag(rt2), .resp_word(rd2));

    // timestamp model
    int idxw, offw, ways;
    bit m_valid [4][4];
    int m_tag   [4][4];
    int m_stamp [4][4];
    int now;

    task automatic check(input string rq, input string what, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s %s actual=%0d expected=%0d", rq, what, act, exp);
        end
    endtask

    task automatic model_clear(input int d);
        case (d)
            0: begin idxw = 2; offw = 1; ways = 3; end
            1: begin idxw = 2; offw = 0; ways = 1; end
            default: begin idxw = 0; offw = 1; ways = 4; end
        endcase
        for (int s = 0; s < 4; s++)
            for (int w = 0; w < 4; w++) begin
                m_valid[s][w] = 0; m_tag[s][w] = 0; m_stamp[s][w] = 0;
            end
        now = 1;
    endtask

    task automatic model_ref(input int a, input bit mru, output bit hit, output int way,
                             output bit ev, output int evtag);
        int s, t, best;
        s = (a >> offw) & ((1 << idxw) - 1);
        t = a >> (offw + idxw);
        hit = 0; ev = 0; evtag = 0; way = -1;
        for (int w = 0; w < ways; w++) if (m_valid[s][w] && m_tag[s][w] == t) begin hit = 1; way = w; end
        if (!hit) begin
            for (int w = ways - 1; w >= 0; w--) if (!m_valid[s][w]) way = w;
            if (way < 0) begin
                way = 0; best = m_stamp[s][0];
                for (int w = 1; w < ways; w++)
                    if (mru ? (m_stamp[s][w] > best) : (m_stamp[s][w] < best)) begin
                        best = m_stamp[s][w]; way = w;
                    end
                ev = 1; evtag = m_tag[s][way];
            end
            m_valid[s][way] = 1; m_tag[s][way] = t;
        end
        m_stamp[s][way] = now; now++;
    endtask

    task automatic do_reset();
        @(negedge clk);
        v0 = 0; v1 = 0; v2 = 0; rst_n = 0;
        @(negedge clk);
        rst_n = 1;
        @(negedge clk);
    endtask

    // drive one reference at a negedge, compare at the following negedge
    task automatic apply(input int d, input int a, input bit mru, input string rq);
        bit eh, ee; int ew, et;
        int gv, gh, gw, ge, gt, gd;
        model_ref(a, mru, eh, ew, ee, et);
        case (d)
            0: begin v0 = 1; a0 = 8'(a); p0 = mru; end
            1: begin v1 = 1; a1 = 4'(a); p1 = mru; end
            default: begin v2 = 1; a2 = 8'(a); p2 = mru; end
        endcase
        @(negedge clk);
        case (d)
            0: begin gv = rv0; gh = rh0; gw = rw0; ge = re0; gt = rt0; gd = rd0; end
            1: begin gv = rv1; gh = rh1; gw = rw1; ge = re1; gt = rt1; gd = rd1; end
            default: begin gv = rv2; gh = rh2; gw = rw2; ge = re2; gt = rt2; gd = rd2; end
        endcase
        check("R3", $sformatf("valid addr=%0d", a), gv, 1);
        check(rq, $sformatf("hit addr=%0d", a), gh, eh);
        check(rq, $sformatf("way addr=%0d", a), gw, ew);
        check(eh ? "R7" : rq, $sformatf("evict addr=%0d", a), ge, ee);
        if (ee) check("R12", $sformatf("evict tag addr=%0d", a), gt, et);
        check("R9", $sformatf("word addr=%0d", a), gd, a);
    endtask

    task automatic idle(input int d);
        v0 = 0; v1 = 0; v2 = 0;
        @(negedge clk);
        check("R3", "valid after idle", d == 0 ? rv0 : (d == 1 ? rv1 : rv2), 0);
    endtask

    task automatic t_reset();
        do_reset();
        check("R1", "u0 valid at reset", rv0, 0);
        check("R1", "u1 valid at reset", rv1, 0);
        check("R1", "u2 valid at reset", rv2, 0);
        model_clear(0);
        apply(0, 200, 0, "R1");
        idle(0);
    endtask

    task automatic t_stream_lru();
        int seq [12] = '{5, 182, 45, 4, 189, 86, 188, 12, 183, 42, 188, 251};
        do_reset(); model_clear(0);
        foreach (seq[i]) apply(0, seq[i], 0, "R2");
        idle(0);
    endtask

    task automatic t_block();
        do_reset(); model_clear(0);
        apply(0, 89, 0, "R4");
        apply(0, 88, 0, "R8");
        apply(0, 89, 0, "R8");
        idle(0);
    endtask

    // set 1 (index bits 01): addresses 2,10,18,26 differ only in tag
    task automatic t_evict(input bit mru, input string rq);
        do_reset(); model_clear(0);
        apply(0, 2, mru, "R4");
        apply(0, 10, mru, "R4");
        apply(0, 18, mru, "R4");
        apply(0, 3, mru, "R7");
        apply(0, 26, mru, rq);
        apply(0, 34, mru, rq);
        idle(0);
    endtask

    task automatic t_switch();
        do_reset(); model_clear(0);
        apply(0, 2, 0, "R6");
        apply(0, 10, 1, "R6");
        apply(0, 18, 0, "R6");
        apply(0, 26, 1, "R6");
        apply(0, 34, 0, "R6");
        apply(0, 2, 1, "R6");
        apply(0, 42, 1, "R6");
        idle(0);
    endtask

    task automatic t_direct();
        int seq [5] = '{0, 8, 0, 6, 8};
        int hits = 0;
        do_reset(); model_clear(1);
        foreach (seq[i]) begin
            apply(1, seq[i], 0, "R10");
            hits += rh1;
        end
        check("R10", "hit count", hits, 0);
        idle(1);
    endtask

    task automatic t_full(input bit mru);
        int seq [10] = '{3, 181, 43, 2, 191, 88, 190, 14, 181, 252};
        do_reset(); model_clear(2);
        foreach (seq[i]) apply(2, seq[i], mru, "R11");
        idle(2);
    endtask

    initial begin
        t_reset();
        t_stream_lru();
        t_block();
        t_evict(0, "R5");
        t_evict(1, "R6");
        t_switch();
        t_direct();
        t_full(0);
        t_full(1);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        vectors++; miscompares++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule